// File: doc/BRIEF.md
# Cross-Domain Mailbox Register Pair

This block lets two ports that run on independent clocks hand single 36-bit words to each other, one word in each direction. Port A writes the forward mailbox, and port B reads it. Port B writes the return mailbox, and port A reads it. Each mailbox has an active-low full flag. The writer's clock drives the flag low, and the reader's clock drives it high again. Data still goes into the mailbox register when the flag is already low, so a second write replaces the stored word.

Each port has a mailbox select that chooses between the mailbox and the bulk data path. The bulk storage is outside this block. On port B it appears only as the `fifo_q` input, which the read multiplexer passes to `b_dout` when the mailbox select is low.

Two toggle bits carry each set or clear event across the clock boundary. The writer owns one toggle and the reader owns the other. Each side sees the other side's toggle through a two-stage synchronizer and uses that view to decide whether its own event is due. The flag pin is the inverted XOR of the two raw toggles. It therefore changes on the clock edge of the side that causes the change.

Top module: `xdom_mailbox`

## Requirements
- R1: A port A access with `a_cs_n` low, `a_en` high, `a_wr` high and `a_mb` high stores `a_din` in the forward mailbox. The same `clk_a` rising edge drives `mbf1_n` low.
- R2: A port B access with `b_cs_n` low, `b_en` high, `b_wr` high and `b_mb` high stores `b_din` in the return mailbox. The same `clk_b` rising edge drives `mbf2_n` low.
- R3: A port B access with `b_wr` low and `b_mb` high, made while the forward mailbox is full, drives `mbf1_n` high on that `clk_b` edge. The same access made while the mailbox is empty leaves `mbf1_n` high.
- R4: A port A access with `a_wr` low and `a_mb` high, made while the return mailbox is full, drives `mbf2_n` high on that `clk_a` edge.
- R5: While `rst_n` is low, `mbf1_n` and `mbf2_n` are both high and both mailbox registers hold zero.
- R6: `b_dout` equals the forward mailbox when `b_mb` is high and equals `fifo_q` when `b_mb` is low.
- R7: `a_dout` equals the return mailbox when `a_mb` is high and is all zeros when `a_mb` is low.
- R8: An access with chip select high or enable low changes no mailbox register and no flag.
- R9: Writing a mailbox whose flag is already low replaces the stored word and leaves the flag low.
- R10: Accesses with the mailbox select low change neither mailbox nor either flag. This includes a port B read of the bulk path while the forward mailbox is full.
- R11: Both directions work independently. Writes to both mailboxes on the same edges leave both flags low, and each word reaches its own reader.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, independent of clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| a_cs_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mb | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A read data (return mailbox) |
| b_cs_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mb | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| fifo_q | input | 36 | Word from the bulk path, presented on a port B read |
| b_dout | output | 36 | Port B read data |
| mbf1_n | output | 1 | Forward mailbox full, active low |
| mbf2_n | output | 1 | Return mailbox full, active low |

## Verification
The flag assertions assume a handover discipline at the ports. After one side changes a flag, the other side does not act on that mailbox until at least two clock edges of its own have passed. Inside one clock cycle of the observing side, a flag is therefore changed only by that side. The stimulus follows this rule. After every access it waits several cycles of both clocks before the next access and before it samples the flags and both read buses. The only exception is the directed case with writes in both directions at once. That case touches two different mailboxes, so neither flag has two drivers in the same cycle.

// File: rtl/xdom_mailbox.sv
module xdom_mailbox #(
  parameter int WIDTH = 36,
  parameter int SYNC  = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic             a_cs_n,
  input  logic             a_en,
  input  logic             a_wr,
  input  logic             a_mb,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  input  logic             b_cs_n,
  input  logic             b_en,
  input  logic             b_wr,
  input  logic             b_mb,
  input  logic [WIDTH-1:0] b_din,
  input  logic [WIDTH-1:0] fifo_q,
  output logic [WIDTH-1:0] b_dout,
  output logic             mbf1_n,
  output logic             mbf2_n
);

  logic [WIDTH-1:0] mail_fwd, mail_ret;
  logic fwd_put, fwd_take, ret_put, ret_take;
  logic [SYNC-1:0] fwd_take_sa, ret_put_sa;
  logic [SYNC-1:0] fwd_put_sb, ret_take_sb;

  wire a_go = !a_cs_n && a_en && a_mb;
  wire b_go = !b_cs_n && b_en && b_mb;
  wire a_put = a_go && a_wr;
  wire a_get = a_go && !a_wr;
  wire b_put = b_go && b_wr;
  wire b_get = b_go && !b_wr;

  wire fwd_empty_a = fwd_put == fwd_take_sa[SYNC-1];
  wire ret_full_a  = ret_put_sa[SYNC-1] != ret_take;
  wire fwd_full_b  = fwd_put_sb[SYNC-1] != fwd_take;
  wire ret_empty_b = ret_put == ret_take_sb[SYNC-1];

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mail_fwd    <= '0;
      fwd_put     <= 1'b0;
      ret_take    <= 1'b0;
      fwd_take_sa <= '0;
      ret_put_sa  <= '0;
    end else begin
      fwd_take_sa <= {fwd_take_sa[SYNC-2:0], fwd_take};
      ret_put_sa  <= {ret_put_sa[SYNC-2:0], ret_put};
      if (a_put) begin
        mail_fwd <= a_din;
        if (fwd_empty_a) fwd_put <= ~fwd_put;
      end
      if (a_get && ret_full_a) ret_take <= ~ret_take;
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mail_ret    <= '0;
      ret_put     <= 1'b0;
      fwd_take    <= 1'b0;
      fwd_put_sb  <= '0;
      ret_take_sb <= '0;
    end else begin
      fwd_put_sb  <= {fwd_put_sb[SYNC-2:0], fwd_put};
      ret_take_sb <= {ret_take_sb[SYNC-2:0], ret_take};
      if (b_put) begin
        mail_ret <= b_din;
        if (ret_empty_b) ret_put <= ~ret_put;
      end
      if (b_get && fwd_full_b) fwd_take <= ~fwd_take;
    end
  end

  assign mbf1_n = ~(fwd_put ^ fwd_take);
  assign mbf2_n = ~(ret_put ^ ret_take);
  assign a_dout = a_mb ? mail_ret : '0;
  assign b_dout = b_mb ? mail_fwd : fifo_q;

  assert_fwd_write_R1: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_put |=> (mail_fwd == $past(a_din)) && !mbf1_n);
  assert_ret_write_R2: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_put |=> (mail_ret == $past(b_din)) && !mbf2_n);
  assert_fwd_clear_R3: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_get && fwd_full_b) |=> mbf1_n);
  assert_ret_clear_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_get && ret_full_a) |=> mbf2_n);
  assert_reset_flags_R5: assert property (@(posedge clk_a)
    !rst_n |-> (mbf1_n && mbf2_n && mail_fwd == '0));
  assert_fwd_hold_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_put |=> $stable(mail_fwd));
  assert_ret_hold_R8: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_put |=> $stable(mail_ret));

  initial begin
    assert (SYNC >= 2) else $error("SYNC must be at least 2");
  end

endmodule

// File: tb/xdom_mailbox_test.sv
module xdom_mailbox_test;
  localparam int W = 36;
  localparam int N = 10;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_cs_n = 1, a_en = 0, a_wr = 0, a_mb = 1;
  logic b_cs_n = 1, b_en = 0, b_wr = 0, b_mb = 1;
  logic [W-1:0] a_din = '0, b_din = '0, fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic mbf1_n, mbf2_n;
  int checks = 0, errors = 0;

  always #10 clk_a = ~clk_a;
  always #7  clk_b = ~clk_b;

  xdom_mailbox uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mb(a_mb), .a_din(a_din), .a_dout(a_dout),
    .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mb(b_mb), .b_din(b_din),
    .fifo_q(fifo_q), .b_dout(b_dout), .mbf1_n(mbf1_n), .mbf2_n(mbf2_n)
  );

  // op: 0 A writes fwd, 1 B reads fwd, 2 B writes ret, 3 A reads ret,
  //     4 A write with cs high, 5 B write with enable low,
  //     6 A write with mb low, 7 B read with mb low
  localparam int OP [N] = '{0, 0, 7, 1, 1, 2, 3, 4, 5, 6};
  localparam logic [W-1:0] DAT [N] = '{36'h0_1234_5678, 36'hF_0000_00AA, 36'h0, 36'h0, 36'h0,
                                      36'h9_8765_4321, 36'h0, 36'h3_3333_3333, 36'h5_5555_5555,
                                      36'h6_6666_6666};
  localparam logic EF1 [N] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam logic EF2 [N] = '{1, 1, 1, 1, 1, 0, 1, 1, 1, 1};
  localparam logic [W-1:0] EM1 [N] = '{36'h0_1234_5678, 36'hF_0000_00AA, 36'hF_0000_00AA,
                                      36'hF_0000_00AA, 36'hF_0000_00AA, 36'hF_0000_00AA,
                                      36'hF_0000_00AA, 36'hF_0000_00AA, 36'hF_0000_00AA,
                                      36'hF_0000_00AA};
  localparam logic [W-1:0] EM2 [N] = '{36'h0, 36'h0, 36'h0, 36'h0, 36'h0, 36'h9_8765_4321,
                                      36'h9_8765_4321, 36'h9_8765_4321, 36'h9_8765_4321,
                                      36'h9_8765_4321};
  localparam string TAG [N] = '{"R1", "R9", "R10", "R3", "R3", "R2", "R4", "R8", "R8", "R10"};

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_a(input logic wr, input logic mb, input logic csn, input logic en,
                         input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs_n = csn; a_en = en; a_wr = wr; a_mb = mb; a_din = d;
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0; a_wr = 0; a_mb = 1;
  endtask

  task automatic drive_b(input logic wr, input logic mb, input logic csn, input logic en,
                         input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs_n = csn; b_en = en; b_wr = wr; b_mb = mb; b_din = d;
    @(negedge clk_b);
    b_cs_n = 1; b_en = 0; b_wr = 0; b_mb = 1;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_a);
    repeat (6) @(negedge clk_b);
    #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_a);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_a);
    // R5: reset state
    check("R5 mbf1_n", {35'h0, mbf1_n}, 36'h1);
    check("R5 mbf2_n", {35'h0, mbf2_n}, 36'h1);
    check("R5 fwd", b_dout, '0);
    check("R5 ret", a_dout, '0);
    rst_n = 1;
    settle();

    for (int i = 0; i < N; i++) begin
      case (OP[i])
        0: drive_a(1, 1, 0, 1, DAT[i]);
        1: drive_b(0, 1, 0, 1, DAT[i]);
        2: drive_b(1, 1, 0, 1, DAT[i]);
        3: drive_a(0, 1, 0, 1, DAT[i]);
        4: drive_a(1, 1, 1, 1, DAT[i]);
        5: drive_b(1, 1, 0, 0, DAT[i]);
        6: drive_a(1, 0, 0, 1, DAT[i]);
        default: drive_b(0, 0, 0, 1, DAT[i]);
      endcase
      settle();
      check({TAG[i], " mbf1_n"}, {35'h0, mbf1_n}, {35'h0, EF1[i]});
      check({TAG[i], " mbf2_n"}, {35'h0, mbf2_n}, {35'h0, EF2[i]});
      check({TAG[i], " fwd word"}, b_dout, EM1[i]);
      check({TAG[i], " ret word"}, a_dout, EM2[i]);
    end

    // R6: bulk path on port B when mailbox select is low
    fifo_q = 36'hA_BCDE_F012;
    b_mb = 0; #1;
    check("R6 fifo path", b_dout, 36'hA_BCDE_F012);
    b_mb = 1; #1;
    check("R6 mailbox path", b_dout, 36'hF_0000_00AA);
    // R7: port A sees zeros when mailbox select is low
    a_mb = 0; #1;
    check("R7 zero when unselected", a_dout, '0);
    a_mb = 1; #1;

    // R1 timing: flag drops on the writing clk_a edge itself
    @(negedge clk_a);
    a_cs_n = 0; a_en = 1; a_wr = 1; a_mb = 1; a_din = 36'h1_1111_0000;
    @(posedge clk_a); #1;
    check("R1 same-edge flag", {35'h0, mbf1_n}, 36'h0);
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0; a_wr = 0;
    settle();
    drive_b(0, 1, 0, 1, '0);
    settle();
    check("R3 cleared", {35'h0, mbf1_n}, 36'h1);

    // R11: both directions written together
    fork
      drive_a(1, 1, 0, 1, 36'h7_0000_0007);
      drive_b(1, 1, 0, 1, 36'h8_0000_0008);
    join
    settle();
    check("R11 mbf1_n", {35'h0, mbf1_n}, 36'h0);
    check("R11 mbf2_n", {35'h0, mbf2_n}, 36'h0);
    check("R11 fwd word", b_dout, 36'h7_0000_0007);
    check("R11 ret word", a_dout, 36'h8_0000_0008);

    // R5: reset from a loaded state
    rst_n = 0; #3;
    check("R5 reload mbf1_n", {35'h0, mbf1_n}, 36'h1);
    check("R5 reload mbf2_n", {35'h0, mbf2_n}, 36'h1);
    check("R5 reload fwd", b_dout, '0);
    check("R5 reload ret", a_dout, '0);
    repeat (2) @(negedge clk_a);
    rst_n = 1;
    settle();
    finish_run();
  end
endmodule